// File: doc/BRIEF.md
# UART Modem Line Monitor and Receive Flow Gate

This block sits beside a UART's receive FIFO and handles the modem handshake lines. It has four active-low inputs: clear-to-send, data-set-ready, ring and carrier-detect. Each input passes through a two-stage synchroniser, and the block reports the asserted level of each line, which is the complement of the pin. When a line changes, the block latches a change flag. The ring line is the exception: its flag is set only when a ring ends. Any latched flag raises a modem interrupt request. The flags stay set until software reads the status and pulses `stat_rd_i`.

The block also drives the request-to-send and data-terminal-ready outputs. In manual mode both outputs follow control bits. In automatic flow mode, request-to-send is withdrawn when the receive FIFO fill level, an input here, reaches a programmable threshold. It is granted again only once the fill has fallen four entries below that threshold. A threshold under four turns the mechanism off. The comparator result is reported as a status bit and never raises an interrupt.

Top module: `uart_modem_flow`

## Requirements
- R1: `line_state_o` reports the complement of the synchronised inputs, with bit 0 = clear-to-send, 1 = data-set-ready, 2 = ring and 3 = carrier-detect. A pin change shows there after the second rising clock edge.
- R2: `delta_o` uses the same bit order. Bits 0, 1 and 3 are set one edge after `line_state_o` changes, in either direction.
- R3: `delta_o[2]` is set only when the ring line stops being asserted (pin goes 0 to 1). Asserting the ring line leaves the bit clear.
- R4: `modem_irq_o` is high exactly while any `delta_o` bit is set.
- R5: With `flow_auto_i` high and `flow_thr_i` >= 4, a fill level >= `flow_thr_i` drives `flow_trig_o` high and `rts_n_o` high (released) after the next edge.
- R6: Once released in automatic mode, `rts_n_o` returns low only after an edge with fill level <= `flow_thr_i` - 4. Between the two bounds it holds its state.
- R7: A `flow_thr_i` below 4 keeps `flow_trig_o` low and, in automatic mode, `rts_n_o` low.
- R8: In manual mode, `rts_n_o` = NOT `rts_ctl_i` with no clock delay. In every mode, `dtr_n_o` = NOT `dtr_ctl_i`.
- R9: A pulse on `stat_rd_i` clears all `delta_o` bits at the next edge. A change detected at that same edge still sets its bit.
- R10: After reset, `line_state_o`, `delta_o`, `modem_irq_o` and `flow_trig_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring pin, active low |
| dcd_n_i | input | 1 | Carrier-detect pin, active low |
| stat_rd_i | input | 1 | Status read strobe, clears change flags |
| flow_auto_i | input | 1 | Automatic flow mode enable |
| rts_ctl_i | input | 1 | Manual request-to-send control bit |
| dtr_ctl_i | input | 1 | Data-terminal-ready control bit |
| flow_thr_i | input | 6 | Flow threshold |
| fifo_level_i | input | 7 | Receive FIFO fill level |
| line_state_o | output | 4 | Asserted line levels |
| delta_o | output | 4 | Latched change flags |
| modem_irq_o | output | 1 | Modem interrupt request |
| flow_trig_o | output | 1 | Flow threshold reached |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| dtr_n_o | output | 1 | Data-terminal-ready pin, active low |

## Verification
The bench sweeps every threshold from 0 to 63 while ramping the fill level from 0 to 64 and back. This exposes an off-by-one comparator, which would release a cycle early or late, and a hysteresis band of the wrong width, which would grant request-to-send too soon on the way down. It also exposes thresholds under four that are not treated as off, which would leave the line withdrawn at low fill. For each line, the bench checks the exact edge where the level and then the flag appear. A ring flag set on the leading edge, or a flag set at the wrong edge, is caught. A read that collides with a new change checks that the clear does not swallow the event.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int NUM_LINES = 4;
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;
  localparam int FLOW_HYST = 4;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '1;  // idle pins are high
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
  parameter int W      = 4,
  parameter int RI_IDX = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] evt;

  for (genvar g = 0; g < W; g++) begin : g_evt
    if (g == RI_IDX) begin : g_trail
      assign evt[g] = prev_q[g] & ~lvl_i[g];
    end else begin : g_any
      assign evt[g] = prev_q[g] ^ lvl_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= (clr_i ? '0 : flag_q) | evt;  // new event beats clear
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/flow_gate.sv
module flow_gate #(
  parameter int LVL_W = 7,
  parameter int THR_W = 6,
  parameter int HYST  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             trig_o,
  output logic             hold_o
);
  localparam int CW = ((LVL_W > THR_W) ? LVL_W : THR_W) + 2;

  logic [CW-1:0] lvl_x, thr_x;
  logic          en, at_thr, below_band;
  logic          trig_q, hold_q;

  assign lvl_x      = CW'(level_i);
  assign thr_x      = CW'(thr_i);
  assign en         = thr_x >= CW'(HYST);
  assign at_thr     = en && (lvl_x >= thr_x);
  assign below_band = (lvl_x + CW'(HYST)) <= thr_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      trig_q <= at_thr;
      if (!en || below_band) hold_q <= 1'b0;
      else if (at_thr)       hold_q <= 1'b1;
    end
  end

  assign trig_o = trig_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/uart_modem_flow.sv
module uart_modem_flow
  import modem_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int THR_W       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cts_n_i,
  input  logic                 dsr_n_i,
  input  logic                 ri_n_i,
  input  logic                 dcd_n_i,
  input  logic                 stat_rd_i,
  input  logic                 flow_auto_i,
  input  logic                 rts_ctl_i,
  input  logic                 dtr_ctl_i,
  input  logic [THR_W-1:0]     flow_thr_i,
  input  logic [LVL_W-1:0]     fifo_level_i,
  output logic [NUM_LINES-1:0] line_state_o,
  output logic [NUM_LINES-1:0] delta_o,
  output logic                 modem_irq_o,
  output logic                 flow_trig_o,
  output logic                 rts_n_o,
  output logic                 dtr_n_o
);
  logic [NUM_LINES-1:0] pins_n, pins_sync_n, lvl;
  logic                 hold;

  always_comb begin
    pins_n         = '1;
    pins_n[LN_CTS] = cts_n_i;
    pins_n[LN_DSR] = dsr_n_i;
    pins_n[LN_RI]  = ri_n_i;
    pins_n[LN_DCD] = dcd_n_i;
  end

  modem_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pins_n), .q_o(pins_sync_n)
  );

  assign lvl = ~pins_sync_n;

  modem_delta #(.W(NUM_LINES), .RI_IDX(LN_RI)) u_delta (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .clr_i(stat_rd_i), .flag_o(delta_o)
  );

  flow_gate #(.LVL_W(LVL_W), .THR_W(THR_W), .HYST(FLOW_HYST)) u_flow (
    .clk_i (clk_i), .rst_ni(rst_ni), .level_i(fifo_level_i), .thr_i(flow_thr_i),
    .trig_o(flow_trig_o), .hold_o(hold)
  );

  assign line_state_o = lvl;
  assign modem_irq_o  = |delta_o;
  assign rts_n_o      = flow_auto_i ? hold : ~rts_ctl_i;
  assign dtr_n_o      = ~dtr_ctl_i;
endmodule

// File: rtl/modem_flow_chk.sv
module modem_flow_chk #(
  parameter int LVL_W = 7,
  parameter int THR_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stat_rd_i,
  input logic             flow_auto_i,
  input logic [THR_W-1:0] flow_thr_i,
  input logic [LVL_W-1:0] fifo_level_i,
  input logic [3:0]       line_state_o,
  input logic [3:0]       delta_o,
  input logic             modem_irq_o,
  input logic             flow_trig_o,
  input logic             rts_n_o
);
  AST_CTS_CHANGE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_state_o[0] != $past(line_state_o[0]) |=> delta_o[0]); // R2

  AST_RI_LEAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(line_state_o[2]) && !delta_o[2]) |=> !delta_o[2]); // R3

  AST_IRQ_FALL_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(modem_irq_o) |-> $past(stat_rd_i)); // R9

  AST_LOW_THR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'($past(flow_thr_i)) < 4) |-> !flow_trig_o); // R7

  AST_RTS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_auto_i && int'($past(flow_thr_i)) >= 4 &&
     int'($past(fifo_level_i)) >= int'($past(flow_thr_i))) |-> rts_n_o); // R5

  AST_RTS_HOLD_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_auto_i && $past(flow_auto_i) && $past(rts_n_o) && int'($past(flow_thr_i)) >= 4 &&
     int'($past(fifo_level_i)) + 4 > int'($past(flow_thr_i))) |-> rts_n_o); // R6
endmodule

bind uart_modem_flow modem_flow_chk #(.LVL_W(LVL_W), .THR_W(THR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stat_rd_i   (stat_rd_i),
  .flow_auto_i (flow_auto_i),
  .flow_thr_i  (flow_thr_i),
  .fifo_level_i(fifo_level_i),
  .line_state_o(line_state_o),
  .delta_o     (delta_o),
  .modem_irq_o (modem_irq_o),
  .flow_trig_o (flow_trig_o),
  .rts_n_o     (rts_n_o)
);

// File: tb/uart_modem_flow_bench.sv
module uart_modem_flow_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cts_n_i = 1'b1, dsr_n_i = 1'b1, ri_n_i = 1'b1, dcd_n_i = 1'b1;
  logic       stat_rd_i = 1'b0, flow_auto_i = 1'b0, rts_ctl_i = 1'b0, dtr_ctl_i = 1'b0;
  logic [5:0] flow_thr_i = '0;
  logic [6:0] fifo_level_i = '0;
  logic [3:0] line_state_o, delta_o;
  logic       modem_irq_o, flow_trig_o, rts_n_o, dtr_n_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit m_hold = 0;

  always #2 clk_i = ~clk_i;

  uart_modem_flow u_uart_modem_flow (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_pin(int i, logic v);
    case (i)
      0: cts_n_i = v;
      1: dsr_n_i = v;
      2: ri_n_i  = v;
      default: dcd_n_i = v;
    endcase
  endtask

  task automatic do_read();
    stat_rd_i = 1'b1;
    @(negedge clk_i);
    stat_rd_i = 1'b0;
  endtask

  task automatic flow_step(int lvl);
    int thr = int'(flow_thr_i);
    bit en = thr >= 4;
    fifo_level_i = 7'(lvl);
    if (!en || lvl + 4 <= thr) m_hold = 0;
    else if (lvl >= thr) m_hold = 1;
    @(negedge clk_i);
    chk(lvl >= thr ? "R5 trig" : "R7 trig", 32'(flow_trig_o), 32'(en && lvl >= thr));
    chk(!en ? "R7 rts" : (lvl >= thr ? "R5 rts" : "R6 rts"), 32'(rts_n_o), 32'(m_hold));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 state", 32'(line_state_o), 0);
    chk("R10 delta", 32'(delta_o), 0);
    chk("R10 irq", 32'(modem_irq_o), 0);
    chk("R10 trig", 32'(flow_trig_o), 0);

    for (int i = 0; i < 4; i++) begin
      set_pin(i, 1'b0);
      @(negedge clk_i);
      chk("R1 state early", 32'(line_state_o[i]), 0);
      @(negedge clk_i);
      chk("R1 state", 32'(line_state_o), 32'(1 << i));
      chk("R2 delta not yet", 32'(delta_o), 0);
      @(negedge clk_i);
      chk(i == 2 ? "R3 lead" : "R2 assert", 32'(delta_o), i == 2 ? 0 : 32'(1 << i));
      chk("R4 irq", 32'(modem_irq_o), 32'(i != 2));
      do_read();
      chk("R9 clear", 32'(delta_o), 0);
      chk("R4 irq low", 32'(modem_irq_o), 0);
      set_pin(i, 1'b1);
      repeat (2) @(negedge clk_i);
      chk("R1 release", 32'(line_state_o), 0);
      @(negedge clk_i);
      chk(i == 2 ? "R3 trail" : "R2 release", 32'(delta_o), 32'(1 << i));
      chk("R4 irq set", 32'(modem_irq_o), 1);
      do_read();
      // read colliding with a new change
      set_pin(i, 1'b0);
      repeat (2) @(negedge clk_i);
      stat_rd_i = 1'b1;
      @(negedge clk_i);
      stat_rd_i = 1'b0;
      chk("R9 collide", 32'(delta_o), i == 2 ? 0 : 32'(1 << i));
      set_pin(i, 1'b1);
      repeat (4) @(negedge clk_i);
      do_read();
      chk("R9 final clear", 32'(delta_o), 0);
    end

    for (int k = 0; k < 4; k++) begin
      rts_ctl_i = k[0];
      dtr_ctl_i = k[1];
      #1;
      chk("R8 rts", 32'(rts_n_o), 32'(!k[0]));
      chk("R8 dtr", 32'(dtr_n_o), 32'(!k[1]));
      @(negedge clk_i);
    end

    flow_auto_i = 1'b1;
    fifo_level_i = '0;
    @(negedge clk_i);
    m_hold = 0;
    for (int t = 0; t < 64; t++) begin
      flow_thr_i = 6'(t);
      for (int l = 0; l <= 64; l++) flow_step(l);
      for (int l = 64; l >= 0; l--) flow_step(l);
    end
    dtr_ctl_i = 1'b1;
    #1;
    chk("R8 dtr auto", 32'(dtr_n_o), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule